// File: doc/BRIEF.md
# Streaming Separable 3x3 Blur

This block smooths a greyscale image that arrives as a raster scan, one pixel per accepted beat, left to right within a line and line after line. It first applies a symmetric three-tap weighting along each line. It then applies the same weighting across three neighbouring lines. The blurred image leaves in the same raster order. No frame buffer is used. The last three input pixels sit in a small window whose slot is the column number modulo 3. The horizontal results of the last three lines sit in a line store whose slot is the line number modulo 3.

Both pixel streams use valid/ready. An output beat moves when `out_valid` and `out_ready` are both high, and an input beat moves when `in_valid` and `in_ready` are both high. The block holds an output beat unchanged until it is taken. While the output register is full and not being taken, `in_ready` stays low, so back-pressure on the output stalls the input. Output pixel j is produced on the same edge that accepts input pixel j+W+1. The final W+1 output pixels lie on the bottom and right borders, so the block emits them by itself after the last input pixel, and refuses input until it has done so. Line ends are derived from the width parameter. A start-of-frame flag on an input beat forces that beat to column 0, row 0.

Top module: `gblur_stream`

## Requirements
- R1: Each frame of IMG_W x IMG_H accepted pixels yields exactly IMG_W x IMG_H output beats in raster order. `out_sof` is high only on output (0,0) and `out_eol` is high only on output column IMG_W-1.
- R2: An interior output at (x,y) is computed in two steps, both using integer division that truncates. First, for each line r in {y-1, y, y+1}, h(x,r) = (E*p(x-1,r) + C*p(x,r) + E*p(x+1,r)) / (C+2E). Then the output is (E*h(x,y-1) + C*h(x,y) + E*h(x,y+1)) / (C+2E). Each step's result is limited to 255. The defaults are C=2 and E=1.
- R3: Every output with x=0, x=IMG_W-1, y=0 or y=IMG_H-1 is 0.
- R4: Within a frame, the number of output beats loaded always equals max(0, accepted inputs - IMG_W - 1).
- R5: After the last pixel of a frame is accepted, the block emits the remaining IMG_W+1 outputs on its own. `in_ready` stays low until the last of these is loaded.
- R6: While `out_valid` is high and `out_ready` is low, the output beat does not change on the next cycle, and `in_ready` is low.
- R7: No intermediate sum overflows. A frame of all-255 pixels gives 255 at every interior position.
- R8: An accepted beat with `in_sof` high is treated as pixel (0,0) of a new frame, even in the middle of a frame. The next output is then the new frame's (0,0) with `out_sof` high.
- R9: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1. The next accepted pixel is taken as (0,0) even when `in_sof` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take the input pixel |
| in_pix | input | PIX_W | Input pixel value |
| in_sof | input | 1 | Input pixel is (0,0) of a frame |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | PIX_W | Blurred pixel value |
| out_sof | output | 1 | Output pixel is (0,0) |
| out_eol | output | 1 | Output pixel is the last column of its line |

## Verification
The filter is driven with several images:
- A diagonal ramp exposes wrong tap placement or swapped line slots, because every neighbour differs.
- A single bright impulse shows the exact 3x3 footprint and where it lands relative to the borders.
- An all-255 frame exposes overflow or lost saturation.
- Pseudo-random frames under random output back-pressure test stall handling, the fixed lag and the self-driven drain together.
- A frame cut short by a new start-of-frame, plus a first frame sent without the flag, test the counter restart rules.

// File: rtl/gblur_pkg.sv
package gblur_pkg;

  typedef enum logic {
    SCAN_FEED  = 1'b0,
    SCAN_DRAIN = 1'b1
  } scan_mode_e;

  // next index of a mod-3 rotation (i+1 mod 3, equals i-2 mod 3)
  function automatic logic [1:0] m3_step(input logic [1:0] v);
    return (v == 2'd2) ? 2'd0 : v + 2'd1;
  endfunction

  // previous index of a mod-3 rotation (i-1 mod 3)
  function automatic logic [1:0] m3_back(input logic [1:0] v);
    return (v == 2'd0) ? 2'd2 : v - 2'd1;
  endfunction

endpackage

// File: rtl/gblur_tap3.sv
module gblur_tap3 #(
  parameter int PIX_W  = 8,
  parameter int COEF_C = 2,
  parameter int COEF_E = 1,
  parameter int SUM_W  = 18
) (
  input  logic [PIX_W-1:0] tap_a,
  input  logic [PIX_W-1:0] tap_m,
  input  logic [PIX_W-1:0] tap_b,
  output logic [SUM_W-1:0] norm_raw,
  output logic [PIX_W-1:0] norm_pix
);
  localparam int TOTAL = COEF_C + 2 * COEF_E;
  localparam bit POW2  = (TOTAL & (TOTAL - 1)) == 0;
  localparam int SHIFT = $clog2(TOTAL);
  localparam logic [SUM_W-1:0] WC      = SUM_W'(COEF_C);
  localparam logic [SUM_W-1:0] WE      = SUM_W'(COEF_E);
  localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [SUM_W-1:0] acc;

  assign acc = WE * SUM_W'(tap_a) + WC * SUM_W'(tap_m) + WE * SUM_W'(tap_b);

  generate
    if (POW2) begin : g_shift
      assign norm_raw = acc >> SHIFT;
    end else begin : g_div
      assign norm_raw = acc / SUM_W'(TOTAL);
    end
  endgenerate

  assign norm_pix = (norm_raw > PIX_MAX) ? {PIX_W{1'b1}} : norm_raw[PIX_W-1:0];

endmodule

// File: rtl/gblur_scan.sv
module gblur_scan
  import gblur_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 400,
  parameter int COL_W = 10,
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             accept,
  output logic             emit,
  output logic             interior,
  output logic             out_first,
  output logic             out_last_col,
  output logic [COL_W-1:0] cur_col,
  output logic [1:0]       cur_col_m3,
  output logic [1:0]       cur_row_m3
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);

  scan_mode_e       mode_q;
  logic [COL_W-1:0] col_q, ox_q;
  logic [ROW_W-1:0] row_q, oy_q, cur_row;
  logic [1:0]       colm3_q, rowm3_q;
  logic             primed, in_last, out_last, line_end;

  // a start-of-frame beat is position (0,0) whatever the counters say
  assign cur_col    = in_sof ? '0 : col_q;
  assign cur_row    = in_sof ? '0 : row_q;
  assign cur_col_m3 = in_sof ? 2'd0 : colm3_q;
  assign cur_row_m3 = in_sof ? 2'd0 : rowm3_q;

  assign in_ready = (mode_q == SCAN_FEED) && slot_free;
  assign accept   = in_valid && in_ready;

  // input index >= IMG_W+1 releases output index (input - IMG_W - 1)
  assign primed   = ((cur_row != '0) && (cur_col != '0)) || (cur_row > ROW_W'(1));
  assign emit     = (accept && primed) || ((mode_q == SCAN_DRAIN) && slot_free);

  assign line_end = (cur_col == LAST_COL);
  assign in_last  = line_end && (cur_row == LAST_ROW);
  assign out_last = (ox_q == LAST_COL) && (oy_q == LAST_ROW);

  assign interior     = (ox_q != '0) && (ox_q != LAST_COL) && (oy_q != '0) && (oy_q != LAST_ROW);
  assign out_first    = (ox_q == '0) && (oy_q == '0);
  assign out_last_col = (ox_q == LAST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SCAN_FEED;
      col_q   <= '0;
      row_q   <= '0;
      colm3_q <= 2'd0;
      rowm3_q <= 2'd0;
      ox_q    <= '0;
      oy_q    <= '0;
    end else begin
      if (accept) begin
        if (line_end) begin
          col_q   <= '0;
          colm3_q <= 2'd0;
          if (cur_row == LAST_ROW) begin
            row_q   <= '0;
            rowm3_q <= 2'd0;
          end else begin
            row_q   <= cur_row + ROW_W'(1);
            rowm3_q <= m3_step(cur_row_m3);
          end
        end else begin
          col_q   <= cur_col + COL_W'(1);
          colm3_q <= m3_step(cur_col_m3);
          row_q   <= cur_row;
          rowm3_q <= cur_row_m3;
        end
      end

      if (accept && in_last) begin
        mode_q <= SCAN_DRAIN;
      end else if (emit && out_last) begin
        mode_q <= SCAN_FEED;
      end

      if (accept && in_sof) begin
        ox_q <= '0;
        oy_q <= '0;
      end else if (emit) begin
        if (ox_q == LAST_COL) begin
          ox_q <= '0;
          oy_q <= (oy_q == LAST_ROW) ? '0 : oy_q + ROW_W'(1);
        end else begin
          ox_q <= ox_q + COL_W'(1);
        end
      end
    end
  end

  AST_MOD3_RANGE: assert property (@(posedge clk) disable iff (rst)
    (colm3_q != 2'd3) && (rowm3_q != 2'd3)); // R2

  AST_DRAIN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (accept && in_last) |=> !in_ready); // R5

endmodule

// File: rtl/gblur_hpass.sv
module gblur_hpass
  import gblur_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_C = 2,
  parameter int COEF_E = 1,
  parameter int SUM_W  = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [1:0]       col_m3,
  input  logic [PIX_W-1:0] in_pix,
  output logic [PIX_W-1:0] h_pix
);
  localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [PIX_W-1:0] win_q [3];
  logic [PIX_W-1:0] px_m2, px_m1;
  logic [SUM_W-1:0] h_raw;

  // slot col%3 takes the new pixel; the other two hold columns x-1 and x-2
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) win_q[i] <= '0;
    end else if (accept) begin
      win_q[col_m3] <= in_pix;
    end
  end

  assign px_m2 = win_q[m3_step(col_m3)];
  assign px_m1 = win_q[m3_back(col_m3)];

  gblur_tap3 #(
    .PIX_W (PIX_W),
    .COEF_C(COEF_C),
    .COEF_E(COEF_E),
    .SUM_W (SUM_W)
  ) i_tap (
    .tap_a   (px_m2),
    .tap_m   (px_m1),
    .tap_b   (in_pix),
    .norm_raw(h_raw),
    .norm_pix(h_pix)
  );

  AST_H_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    accept |-> (h_raw <= PIX_MAX)); // R7

endmodule

// File: rtl/gblur_vpass.sv
module gblur_vpass
  import gblur_pkg::*;
#(
  parameter int IMG_W  = 640,
  parameter int PIX_W  = 8,
  parameter int COEF_C = 2,
  parameter int COEF_E = 1,
  parameter int SUM_W  = 18,
  parameter int COL_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [COL_W-1:0] col,
  input  logic [1:0]       row_m3,
  input  logic [PIX_W-1:0] h_pix,
  output logic [PIX_W-1:0] v_pix
);
  localparam logic [SUM_W-1:0] PIX_MAX = SUM_W'((1 << PIX_W) - 1);

  logic [COL_W-1:0]           tap_col;
  logic                       wr_en;
  logic [2:0][PIX_W-1:0]      slot_rd;
  logic [PIX_W-1:0]           line_up2, line_up1;
  logic [SUM_W-1:0]           v_raw;

  // horizontal result for column col-1 of the current line
  assign tap_col = (col == '0) ? '0 : col - COL_W'(1);
  assign wr_en   = accept && (col >= COL_W'(2));

  for (genvar s = 0; s < 3; s++) begin : g_slot
    logic [PIX_W-1:0] mem [IMG_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int c = 0; c < IMG_W; c++) mem[c] <= '0;
      end else if (wr_en && (row_m3 == 2'(s))) begin
        mem[tap_col] <= h_pix;
      end
    end

    assign slot_rd[s] = mem[tap_col];
  end

  // slot (row+1)%3 holds line y-2, slot (row-1)%3 holds line y-1
  assign line_up2 = slot_rd[m3_step(row_m3)];
  assign line_up1 = slot_rd[m3_back(row_m3)];

  gblur_tap3 #(
    .PIX_W (PIX_W),
    .COEF_C(COEF_C),
    .COEF_E(COEF_E),
    .SUM_W (SUM_W)
  ) i_tap (
    .tap_a   (line_up2),
    .tap_m   (line_up1),
    .tap_b   (h_pix),
    .norm_raw(v_raw),
    .norm_pix(v_pix)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    accept |-> (v_raw <= PIX_MAX)); // R7

endmodule

// File: rtl/gblur_stream.sv
module gblur_stream #(
  parameter int IMG_W  = 640,
  parameter int IMG_H  = 400,
  parameter int PIX_W  = 8,
  parameter int COEF_C = 2,
  parameter int COEF_E = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_sof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_sof,
  output logic             out_eol
);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int ROW_W  = $clog2(IMG_H);
  localparam int COEF_W = 8;
  localparam int SUM_W  = PIX_W + COEF_W + 2;

  logic             slot_free, accept, emit, interior, out_first, out_last_col;
  logic [COL_W-1:0] cur_col;
  logic [1:0]       cur_col_m3, cur_row_m3;
  logic [PIX_W-1:0] h_pix, v_pix;

  assign slot_free = !out_valid || out_ready;

  gblur_scan #(
    .IMG_W(IMG_W),
    .IMG_H(IMG_H),
    .COL_W(COL_W),
    .ROW_W(ROW_W)
  ) i_scan (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sof      (in_sof),
    .slot_free   (slot_free),
    .in_ready    (in_ready),
    .accept      (accept),
    .emit        (emit),
    .interior    (interior),
    .out_first   (out_first),
    .out_last_col(out_last_col),
    .cur_col     (cur_col),
    .cur_col_m3  (cur_col_m3),
    .cur_row_m3  (cur_row_m3)
  );

  gblur_hpass #(
    .PIX_W (PIX_W),
    .COEF_C(COEF_C),
    .COEF_E(COEF_E),
    .SUM_W (SUM_W)
  ) i_hpass (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .col_m3(cur_col_m3),
    .in_pix(in_pix),
    .h_pix (h_pix)
  );

  gblur_vpass #(
    .IMG_W (IMG_W),
    .PIX_W (PIX_W),
    .COEF_C(COEF_C),
    .COEF_E(COEF_E),
    .SUM_W (SUM_W),
    .COL_W (COL_W)
  ) i_vpass (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .col   (cur_col),
    .row_m3(cur_row_m3),
    .h_pix (h_pix),
    .v_pix (v_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_pix   <= interior ? v_pix : '0;
      out_sof   <= out_first;
      out_eol   <= out_last_col;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R6

  AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_sof || out_eol)) |-> (out_pix == '0)); // R3

endmodule

// File: tb/test_gblur_stream.sv
`timescale 1ns/1ps
module test_gblur_stream;
  localparam int W = 8, H = 5, PW = 8, CC = 2, CE = 1, TOT = CC + 2 * CE;
  localparam int NPIX = W * H;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_sof = 1'b0, out_ready = 1'b1;
  logic [PW-1:0] in_pix = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic [PW-1:0] out_pix;

  always #2 clk = ~clk;

  gblur_stream #(.IMG_W(W), .IMG_H(H), .PIX_W(PW), .COEF_C(CC), .COEF_E(CE)) i_gblur_stream (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sof(out_sof), .out_eol(out_eol));

  int errors = 0, checks = 0;
  int frame [H][W];
  int exp_pix [$];
  bit exp_sof [$], exp_eol [$], exp_int [$];
  bit bp_on = 0, lag_on = 0, last_acc = 0;
  logic [15:0] lfsr = 16'hACE1;
  int unsigned seed = 32'd12345;
  int in_acc = 0, out_done = 0;
  string frame_tag = "R2";
  bit prev_stall = 0, prev_sof = 0, prev_eol = 0;
  logic [PW-1:0] prev_pix = '0;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int hval(int x, int y);
    int s = (CE * frame[y][x-1] + CC * frame[y][x] + CE * frame[y][x+1]) / TOT;
    return (s > 255) ? 255 : s;
  endfunction

  function automatic int oval(int x, int y);
    int s;
    if (x < 1 || x > W - 2 || y < 1 || y > H - 2) return 0;
    s = (CE * hval(x, y - 1) + CC * hval(x, y) + CE * hval(x, y + 1)) / TOT;
    return (s > 255) ? 255 : s;
  endfunction

  task automatic pre();
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
  endtask

  task automatic post();
    int produced, e;
    #1;
    produced = out_done + (out_valid ? 1 : 0);
    if (prev_stall)
      check(out_valid && out_pix == prev_pix && out_sof == prev_sof && out_eol == prev_eol,
            "R6", "beat held under stall", out_pix, prev_pix);
    if (out_valid && !out_ready)
      check(!in_ready, "R6", "in_ready during stall", in_ready, 0);
    if (lag_on) begin
      if (in_acc < NPIX) begin
        e = (in_acc - W - 1 > 0) ? in_acc - W - 1 : 0;
        check(produced == e, "R4", "outputs loaded vs inputs", produced, e);
      end else if (produced < NPIX) begin
        check(!in_ready, "R5", "in_ready while draining", in_ready, 0);
      end
    end
    if (out_valid && out_ready) begin
      if (exp_pix.size() == 0) begin
        check(0, "R1", "unexpected output beat", out_pix, -1);
      end else begin
        int ep; bit es, ee, ei;
        ep = exp_pix.pop_front(); es = exp_sof.pop_front();
        ee = exp_eol.pop_front(); ei = exp_int.pop_front();
        check(out_pix == PW'(ep), ei ? frame_tag : "R3", "pixel value", out_pix, ep);
        check(out_sof == es, (frame_tag == "R8") ? "R8" : "R1", "out_sof", out_sof, es);
        check(out_eol == ee, "R1", "out_eol", out_eol, ee);
      end
      out_done++;
    end
    last_acc = in_valid && in_ready;
    if (last_acc) in_acc++;
    prev_stall = out_valid && !out_ready;
    prev_pix = out_pix; prev_sof = out_sof; prev_eol = out_eol;
  endtask

  function automatic int pgen(int mode, int x, int y);
    case (mode)
      0: return (x * 29 + y * 41) % 256;
      1: return 255;
      2: return (x == 4 && y == 2) ? 200 : 0;
      default: begin
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'hFF);
      end
    endcase
  endfunction

  task automatic send_frame(int mode, int npix, bit bp, bit use_sof, string tag);
    int nout;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) frame[y][x] = pgen(mode, x, y);
    nout = (npix == NPIX) ? NPIX : ((npix - W - 1 > 0) ? npix - W - 1 : 0);
    for (int j = 0; j < nout; j++) begin
      exp_pix.push_back(oval(j % W, j / W));
      exp_sof.push_back(j == 0);
      exp_eol.push_back((j % W) == W - 1);
      exp_int.push_back((j % W) > 0 && (j % W) < W - 1 && (j / W) > 0 && (j / W) < H - 1);
    end
    frame_tag = tag; bp_on = bp; in_acc = 0; out_done = 0; lag_on = 1;
    for (int k = 0; k < npix; k++) begin
      do begin
        pre();
        in_valid = 1'b1;
        in_pix = PW'(frame[k / W][k % W]);
        in_sof = use_sof && (k == 0);
        post();
      end while (!last_acc);
    end
    pre(); in_valid = 1'b0; in_sof = 1'b0; post();
    while (exp_pix.size() != 0 || out_valid) begin
      pre(); post();
    end
    check(out_done == nout, (npix == NPIX) ? "R1" : "R8", "output beats in frame", out_done, nout);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    pre(); post();
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);
    send_frame(0, NPIX, 0, 0, "R9");   // ramp, no sof: counters start at 0 from reset
    send_frame(1, NPIX, 1, 1, "R7");   // all 255 under back-pressure
    send_frame(2, NPIX, 1, 1, "R2");   // single impulse
    send_frame(3, NPIX, 1, 1, "R2");   // pseudo-random
    send_frame(3, 20, 0, 1, "R2");     // frame cut short
    send_frame(3, NPIX, 1, 1, "R8");   // restart by sof mid-frame
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule